// File: doc/BRIEF.md
# Paged Host Register Window

This block decodes a 32-byte host I/O window for the glue logic of a network adapter. The lowest eight bytes are local control registers held inside the block. Bytes 8 to 15 form a shared data window. A map bit in control byte 0 decides what that data window shows. When the bit is set, it shows the ring controller's sixteen interface registers. When it is clear, it shows a two-page identity ROM. The ROM page is picked by another bit of control byte 0. The controller has sixteen registers but the window is only eight bytes wide. A register-page bit in control byte 1 therefore supplies the top line of the register-select bus, so registers 8 to 15 appear at the same offsets as registers 0 to 7.

Host accesses are single-cycle strobes and may be byte or 16-bit word wide. Words are little-endian: the lower offset goes in the low byte. Read data is registered and appears on the cycle after the strobe. Forwarded controller accesses reach the controller register file on a select/strobe bus in the same cycle as the host strobe. The identity ROM is computed from parameters: manufacturer code, adapter type, revision and a 48-bit station address. Three bytes of configuration mirror come from an input port.

Top module: `host_page_window`

## Requirements
- R1: After reset every control byte reads 0x00 and `bus_rdata` is 0x0000. The data window then shows ROM page 0, so a byte read at offset 8 returns the manufacturer code 0x4D.
- R2: Each of the control bytes at offsets 0 to 7 reads back exactly the value last written to it. This holds for byte writes and for word writes.
- R3: When control byte 0 bit 2 is 1, a host access at offset 8+k (k = 0..7) raises `ctl_en` in the same cycle. `ctl_regsel[2:0]` is then k, and the strobe carries the host's write flag, width and write data. Read data comes back from `ctl_rdata`.
- R4: `ctl_regsel[3]` equals control byte 1 bit 1. With that bit set, offsets 8 to 15 reach controller registers 8 to 15. With it clear, they reach registers 0 to 7.
- R5: ROM page 0 is selected when control byte 0 bit 3 is 0. At window byte k it holds: k=0 manufacturer 0x4D, k=1 adapter type (default 0x08), k=2 revision (default 0x03), k=3..5 `cfg_mirror` bytes [7:0], [15:8], [23:16]. k=6 and k=7 read 0x00.
- R6: ROM page 1 is selected when control byte 0 bit 3 is 1. Window byte 0 reads 0x00, bytes 1 to 6 hold the station address most significant byte first (default A1 B2 C3 D4 E5 F6), and byte 7 reads 0x00.
- R7: While the ROM is mapped, `ctl_en` never rises. Writes to the data window are ignored: the ROM bytes and the controller registers are unchanged afterwards.
- R8: A word access ignores address bit 0. It covers offsets 2j and 2j+1, with the lower offset in bits [7:0]. A byte read returns its byte in bits [7:0] with bits [15:8] zero.
- R9: Offsets 16 to 31 read 0x0000. Writes there change no control byte and raise no `ctl_en`.
- R10: `bus_rdata` changes only on the clock edge that ends a read strobe and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 16 | Host write data (byte writes use bits [7:0]) |
| bus_rdata | output | 16 | Registered host read data |
| cfg_mirror | input | 24 | Three configuration bytes mirrored into ROM page 0 |
| ctl_en | output | 1 | Access strobe to the controller register file |
| ctl_we | output | 1 | Write flag to the controller |
| ctl_word | output | 1 | Width flag to the controller |
| ctl_regsel | output | 4 | Controller register select, top bit from the register page |
| ctl_wdata | output | 16 | Write data to the controller |
| ctl_rdata | input | 16 | Read data from the controller, valid in the strobe cycle |

## Verification
The hardest case to reach is a write aimed at a controller register while the ROM is mapped over it. From the ports, such a write looks exactly like an ignored write unless the bench later proves the register kept its old value. The stimulus first maps the controller and stores a known byte in register 3. It then unmaps the controller and writes a different value to the same offset, counting any `ctl_en` pulses meanwhile. Finally it remaps the controller and reads register 3 back. The upper register bank is reached the same way. The bench writes through one register-page setting and reads the same offset under the other, which shows that the top select line really separates the two banks.

// File: rtl/hwin_pkg.sv
package hwin_pkg;

  // Window layout
  localparam int unsigned WIN_BYTES  = 32;
  localparam int unsigned CTRL_BYTES = 8;
  localparam int unsigned DATA_BASE  = 8;
  localparam int unsigned DATA_BYTES = 8;
  localparam int unsigned AW         = $clog2(WIN_BYTES);
  localparam int unsigned CIW        = $clog2(CTRL_BYTES);
  localparam int unsigned DIW        = $clog2(DATA_BYTES);

  // Control bit positions (decoded by the window logic)
  localparam int unsigned MAP_BIT    = 2;  // control byte 0
  localparam int unsigned ROMPG_BIT  = 3;  // control byte 0
  localparam int unsigned REGPG_BIT  = 1;  // control byte 1

  typedef enum logic [1:0] {
    AREA_CTRL = 2'd0,
    AREA_DATA = 2'd1,
    AREA_NONE = 2'd2
  } area_e;

  // Identity ROM byte for a given page and index
  function automatic logic [7:0] id_byte(
    input logic        page,
    input int unsigned idx,
    input logic [7:0]  mfr,
    input logic [7:0]  kind,
    input logic [7:0]  rev,
    input logic [23:0] cfg,
    input logic [47:0] station
  );
    logic [7:0] b;
    b = 8'h00;
    if (!page) begin
      case (idx)
        0: b = mfr;
        1: b = kind;
        2: b = rev;
        3: b = cfg[7:0];
        4: b = cfg[15:8];
        5: b = cfg[23:16];
        default: b = 8'h00;
      endcase
    end else begin
      if (idx >= 1 && idx <= 6) b = station[8*(6-idx) +: 8];
    end
    return b;
  endfunction

endpackage

// File: rtl/hwin_decode.sv
module hwin_decode
  import hwin_pkg::*;
(
  input  logic [AW-1:0]  addr,
  input  logic           word,
  output area_e          area,
  output logic [CIW-1:0] ctrl_idx,
  output logic [DIW-1:0] data_idx
);

  localparam logic [AW-1:0] DATA_LO = AW'(DATA_BASE);
  localparam logic [AW-1:0] DATA_HI = AW'(DATA_BASE + DATA_BYTES - 1);
  localparam logic [AW-1:0] CTRL_HI = AW'(CTRL_BYTES - 1);

  logic [AW-1:0] eff;
  logic [AW-1:0] rel;

  always_comb begin
    eff = word ? {addr[AW-1:1], 1'b0} : addr;
    rel = eff - DATA_LO;
    if (eff <= CTRL_HI)                        area = AREA_CTRL;
    else if (eff >= DATA_LO && eff <= DATA_HI) area = AREA_DATA;
    else                                       area = AREA_NONE;
    ctrl_idx = eff[CIW-1:0];
    data_idx = rel[DIW-1:0];
  end

endmodule

// File: rtl/hwin_ctrl_regs.sv
module hwin_ctrl_regs
  import hwin_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_word,
  input  logic [CIW-1:0] idx,
  input  logic [15:0]    wr_data,
  output logic [7:0]     rd_lo,
  output logic [7:0]     rd_hi,
  output logic           map_sel,
  output logic           rom_page,
  output logic           reg_page
);

  logic [7:0] bank_q [CTRL_BYTES];
  logic [7:0] bank_d [CTRL_BYTES];
  logic [CTRL_BYTES-1:0] bank_ce;

  logic [CIW-1:0] idx_hi;
  assign idx_hi = idx | CIW'(1);

  genvar g;
  generate
    for (g = 0; g < CTRL_BYTES; g++) begin : g_byte
      localparam logic [CIW-1:0] MY = CIW'(g);
      always_comb begin
        bank_ce[g] = 1'b0;
        bank_d[g]  = bank_q[g];
        if (wr_en) begin
          if (!wr_word && idx == MY) begin
            bank_ce[g] = 1'b1;
            bank_d[g]  = wr_data[7:0];
          end else if (wr_word && idx == MY) begin
            bank_ce[g] = 1'b1;
            bank_d[g]  = wr_data[7:0];
          end else if (wr_word && idx_hi == MY) begin
            bank_ce[g] = 1'b1;
            bank_d[g]  = wr_data[15:8];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bank_q[g] <= 8'h00;
        else if (bank_ce[g]) bank_q[g] <= bank_d[g];
      end
    end
  endgenerate

  assign rd_lo    = bank_q[idx];
  assign rd_hi    = bank_q[idx_hi];
  assign map_sel  = bank_q[0][MAP_BIT];
  assign rom_page = bank_q[0][ROMPG_BIT];
  assign reg_page = bank_q[1][REGPG_BIT];

  AST_BYTE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word) |=> (bank_q[$past(idx)] == $past(wr_data[7:0]))) // R2
    else $error("control byte lost its written value");

  AST_WORD_HIGH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word) |=> (bank_q[$past(idx_hi)] == $past(wr_data[15:8]))) // R8
    else $error("word write high byte misplaced");

endmodule

// File: rtl/hwin_id_rom.sv
module hwin_id_rom
  import hwin_pkg::*;
#(
  parameter logic [7:0]  MFR_CODE    = 8'h4D,
  parameter logic [7:0]  ADAPTER     = 8'h08,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [47:0] STATION     = 48'hA1B2C3D4E5F6
) (
  input  logic           page,
  input  logic [DIW-1:0] idx,
  input  logic [23:0]    cfg,
  output logic [7:0]     byte_lo,
  output logic [7:0]     byte_hi
);

  logic [7:0] tab0 [DATA_BYTES];
  logic [7:0] tab1 [DATA_BYTES];

  genvar g;
  generate
    for (g = 0; g < DATA_BYTES; g++) begin : g_rom
      assign tab0[g] = id_byte(1'b0, g, MFR_CODE, ADAPTER, REVISION, cfg, STATION);
      assign tab1[g] = id_byte(1'b1, g, MFR_CODE, ADAPTER, REVISION, cfg, STATION);
    end
  endgenerate

  logic [DIW-1:0] idx_hi;
  assign idx_hi  = idx | DIW'(1);
  assign byte_lo = page ? tab1[idx]    : tab0[idx];
  assign byte_hi = page ? tab1[idx_hi] : tab0[idx_hi];

endmodule

// File: rtl/host_page_window.sv
module host_page_window
  import hwin_pkg::*;
#(
  parameter logic [7:0]  MFR_CODE = 8'h4D,
  parameter logic [7:0]  ADAPTER  = 8'h08,
  parameter logic [7:0]  REVISION = 8'h03,
  parameter logic [47:0] STATION  = 48'hA1B2C3D4E5F6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic [23:0]   cfg_mirror,
  output logic          ctl_en,
  output logic          ctl_we,
  output logic          ctl_word,
  output logic [3:0]    ctl_regsel,
  output logic [15:0]   ctl_wdata,
  input  logic [15:0]   ctl_rdata
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // Address decode
  area_e          area;
  logic [CIW-1:0] ctrl_idx;
  logic [DIW-1:0] data_idx;

  hwin_decode u_decode (
    .addr     (bus_addr),
    .word     (bus_word),
    .area     (area),
    .ctrl_idx (ctrl_idx),
    .data_idx (data_idx)
  );

  // Local control bank
  logic       ctrl_wr;
  logic [7:0] ctrl_lo, ctrl_hi;
  logic       map_sel, rom_page, reg_page;

  assign ctrl_wr = bus_en && bus_we && (area == AREA_CTRL);

  hwin_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (ctrl_wr),
    .wr_word  (bus_word),
    .idx      (ctrl_idx),
    .wr_data  (bus_wdata),
    .rd_lo    (ctrl_lo),
    .rd_hi    (ctrl_hi),
    .map_sel  (map_sel),
    .rom_page (rom_page),
    .reg_page (reg_page)
  );

  // Identity ROM
  logic [7:0] rom_lo, rom_hi;

  hwin_id_rom #(
    .MFR_CODE (MFR_CODE),
    .ADAPTER  (ADAPTER),
    .REVISION (REVISION),
    .STATION  (STATION)
  ) u_rom (
    .page    (rom_page),
    .idx     (data_idx),
    .cfg     (cfg_mirror),
    .byte_lo (rom_lo),
    .byte_hi (rom_hi)
  );

  // Controller forwarding
  logic fwd;
  assign fwd        = bus_en && (area == AREA_DATA) && map_sel;
  assign ctl_en     = fwd;
  assign ctl_we     = fwd && bus_we;
  assign ctl_word   = fwd && bus_word;
  assign ctl_regsel = {reg_page, data_idx};
  assign ctl_wdata  = fwd ? bus_wdata : 16'h0000;

  // Read path: next-state and register
  logic        rd_fire;
  logic [15:0] rdata_d;
  logic [15:0] rdata_q;

  assign rd_fire = bus_en && !bus_we;

  always_comb begin
    rdata_d = 16'h0000;
    unique case (area)
      AREA_CTRL: rdata_d = bus_word ? {ctrl_hi, ctrl_lo} : {8'h00, ctrl_lo};
      AREA_DATA: begin
        if (map_sel) rdata_d = bus_word ? ctl_rdata : {8'h00, ctl_rdata[7:0]};
        else         rdata_d = bus_word ? {rom_hi, rom_lo} : {8'h00, rom_lo};
      end
      default:   rdata_d = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     rdata_q <= 16'h0000;
    else if (rd_fire) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  AST_ROM_BLOCKS_CTL: assert property (@(posedge clk) disable iff (!rst_i_n)
    !map_sel |-> !ctl_en) // R7
    else $error("controller strobed while ROM mapped");

  AST_TOP_SELECT: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctl_en |-> (ctl_regsel[3] == reg_page)) // R4
    else $error("top select line does not follow register page");

  AST_CTL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    ctl_en |-> (bus_addr >= AW'(DATA_BASE) && bus_addr < AW'(DATA_BASE + DATA_BYTES))) // R3
    else $error("controller strobed outside data window");

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$past(rd_fire) |-> $stable(bus_rdata)) // R10
    else $error("read data moved without a read");

endmodule

// File: tb/host_page_window_test.sv
`timescale 1ns/1ps
module host_page_window_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we, bus_word;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [23:0] cfg_mirror;
  logic        ctl_en, ctl_we, ctl_word;
  logic [3:0]  ctl_regsel;
  logic [15:0] ctl_wdata;
  logic [15:0] ctl_rdata;

  int checks = 0;
  int errors = 0;
  int ctl_hits = 0;

  always #2 clk = ~clk;

  host_page_window uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_mirror(cfg_mirror), .ctl_en(ctl_en),
    .ctl_we(ctl_we), .ctl_word(ctl_word), .ctl_regsel(ctl_regsel),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  // Controller register file model: 16 x 16 bits, byte writes touch [7:0]
  logic [15:0] cmod [16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) cmod[i] <= 16'h0000;
    end else if (ctl_en && ctl_we) begin
      if (ctl_word) cmod[ctl_regsel] <= ctl_wdata;
      else          cmod[ctl_regsel] <= {cmod[ctl_regsel][15:8], ctl_wdata[7:0]};
    end
  end
  assign ctl_rdata = cmod[ctl_regsel];

  always @(posedge clk) if (ctl_en) ctl_hits <= ctl_hits + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_word = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_word = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic w, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_word = w; bus_addr = a;
    @(negedge clk);
    bus_en = 0; bus_word = 0;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 rdata after reset", bus_rdata, 16'h0000);
    for (int i = 0; i < 8; i++) rd(5'(i), 0, 16'h0000, "R1 control byte zero");
    rd(5'd8, 0, 16'h004D, "R1 ROM page0 visible");
  endtask

  task automatic t_ctrl_rw;
    wr(5'd2, 0, 16'h00A5);
    rd(5'd2, 0, 16'h00A5, "R2 byte readback");
    wr(5'd4, 1, 16'hBEEF);
    rd(5'd4, 0, 16'h00EF, "R2 word low byte");
    rd(5'd5, 0, 16'h00BE, "R2 word high byte");
    rd(5'd4, 1, 16'hBEEF, "R8 word read control");
    wr(5'd7, 1, 16'h1234);
    rd(5'd6, 1, 16'h1234, "R8 odd word address aligned");
    rd(5'd3, 0, 16'h0000, "R2 neighbour untouched");
  endtask

  task automatic t_rom_p0;
    logic [7:0] e [8];
    e = '{8'h4D, 8'h08, 8'h03, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00};
    for (int k = 0; k < 8; k++) rd(5'(8 + k), 0, {8'h00, e[k]}, "R5 ROM page0 byte");
    rd(5'd8, 1, 16'h084D, "R8 ROM word read");
    rd(5'd13, 1, 16'h3322, "R8 ROM odd word address");
  endtask

  task automatic t_rom_p1;
    logic [7:0] e [8];
    e = '{8'h00, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h00};
    wr(5'd0, 0, 16'h0008);
    for (int k = 0; k < 8; k++) rd(5'(8 + k), 0, {8'h00, e[k]}, "R6 ROM page1 byte");
    rd(5'd10, 1, 16'hC3B2, "R6 ROM page1 word");
    wr(5'd0, 0, 16'h0000);
    rd(5'd8, 0, 16'h004D, "R5 back to page0");
  endtask

  task automatic t_ctl_map;
    int h0;
    wr(5'd0, 0, 16'h0004);
    h0 = ctl_hits;
    wr(5'd11, 0, 16'h005A);
    check("R3 strobe forwarded", 16'(ctl_hits - h0), 16'd1);
    check("R3 model reg3", cmod[3], 16'h005A);
    rd(5'd11, 0, 16'h005A, "R3 read reg3");
    wr(5'd1, 0, 16'h0002);
    wr(5'd12, 1, 16'hCAFE);
    check("R4 upper bank reg12", cmod[12], 16'hCAFE);
    check("R4 lower bank reg4 untouched", cmod[4], 16'h0000);
    rd(5'd12, 1, 16'hCAFE, "R4 read upper bank");
    wr(5'd1, 0, 16'h0000);
    rd(5'd12, 1, 16'h0000, "R4 read lower bank");
  endtask

  task automatic t_rom_ignore;
    int h0;
    wr(5'd0, 0, 16'h0000);
    h0 = ctl_hits;
    wr(5'd11, 0, 16'h00EE);
    wr(5'd8, 1, 16'hFFFF);
    rd(5'd11, 0, 16'h0011, "R7 ROM byte unchanged");
    rd(5'd8, 0, 16'h004D, "R7 ROM byte0 unchanged");
    check("R7 no strobe while ROM mapped", 16'(ctl_hits - h0), 16'd0);
    wr(5'd0, 0, 16'h0004);
    rd(5'd11, 0, 16'h005A, "R7 controller reg3 kept");
    wr(5'd0, 0, 16'h0000);
  endtask

  task automatic t_unmapped;
    int h0;
    h0 = ctl_hits;
    wr(5'd20, 0, 16'h0077);
    wr(5'd30, 1, 16'h5555);
    rd(5'd20, 0, 16'h0000, "R9 unmapped byte reads zero");
    rd(5'd30, 1, 16'h0000, "R9 unmapped word reads zero");
    rd(5'd2, 0, 16'h00A5, "R9 control byte unchanged");
    rd(5'd6, 1, 16'h1234, "R9 control word unchanged");
    check("R9 no strobe", 16'(ctl_hits - h0), 16'd0);
  endtask

  task automatic t_hold;
    rd(5'd2, 0, 16'h00A5, "R10 read before hold");
    repeat (3) @(negedge clk);
    check("R10 held over idle", bus_rdata, 16'h00A5);
    wr(5'd3, 0, 16'h0066);
    check("R10 held over write", bus_rdata, 16'h00A5);
    rd(5'd3, 0, 16'h0066, "R10 updated on read");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; bus_en = 0; bus_we = 0; bus_word = 0; bus_addr = '0;
    bus_wdata = '0; cfg_mirror = 24'h332211;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_rom_p0();
    t_rom_p1();
    t_ctl_map();
    t_rom_ignore();
    t_unmapped();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule